// File: doc/BRIEF.md
# Serial Byte-Memory Read Target

This block is the read half of a two-wire serial memory target. It watches the clock and data lines of an open-drain bus and oversamples both with the system clock. From them it picks out bus START, repeated START and STOP events. When a selection byte carries the memory type code and the configured chip-enable value, the block acknowledges it. It can then take a two-byte address through a dummy write, or stream bytes from an internal byte array. The data line is driven only through an output enable that pulls it low.

A host reads in one of three ways. A current read starts from the stored address counter. A random read first loads the counter with a write-direction selection and two address bytes, then uses a repeated START and a read-direction selection. A sequential read continues either of these for as long as the host keeps acknowledging. The counter advances after every byte sent and wraps from the top of the array to zero. A missing host acknowledge sends the block to standby until the next START. The array is a plain register file that is filled through a load port.

Top module: `eeprom_rd_target`

## Requirements
- R1: After reset the data-line output enable is low and the block is idle.
- R2: A selection byte is acknowledged only when its upper four bits are 1010 and the next three bits equal the CHIP_EN parameter. Any other selection byte gets no acknowledge, and the block drives nothing until the next START.
- R3: After a selection byte with bit 0 (direction) equal to 0, the block acknowledges two address bytes, high byte first. The address counter is loaded from the low ADDR_W bits of the 16-bit value, and higher bits are ignored.
- R4: A read-direction selection (bit 0 = 1) with no preceding address phase returns the byte at the current address counter, most significant bit first.
- R5: A repeated START followed by a read-direction selection after an address phase returns the byte at the loaded address.
- R6: If the selection byte after the repeated START carries a wrong chip-enable value, it gets no acknowledge and the block goes to standby. The loaded address counter is kept.
- R7: Each host acknowledge (data low in the ninth clock) after a data byte causes the next consecutive byte to be sent.
- R8: The address counter advances by one after every byte sent, including the last one, which the host does not acknowledge.
- R9: After the highest array address the counter wraps to zero and output continues from address zero.
- R10: A host no-acknowledge (data high in the ninth clock) makes the block release the line and stay idle through further clocks until a START.
- R11: A STOP at any bit position returns the block to idle with the address counter kept. A START at any bit position restarts byte reception.
- R12: The output enable only rises while the clock line is low, and the block only ever pulls the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired result) |
| sda_oe_o | output | 1 | When high, pull the data line low |
| ld_en_i | input | 1 | Array load strobe |
| ld_addr_i | input | ADDR_W | Array load address |
| ld_data_i | input | 8 | Array load byte |

## Verification
The bench builds the block with ADDR_W = 10 and CHIP_EN = 3'b101. A 1024-byte array keeps the load short and makes the wrap from address 1023 to 0 reachable in a few transfers. The address high byte has bits set above the array width, which exercises the rule that unused upper bits are ignored. The non-zero chip-enable value lets the bench build selection bytes that differ from the valid one only in the chip-enable field or only in the type field, and these are the mismatches checked on the first and on the repeated selection.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
   localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
   localparam int         BITS_PER_SLOT = 9;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SEL,
      PH_AHI,
      PH_ALO,
      PH_WAIT,
      PH_TX
   } phase_e;
endpackage

// File: rtl/eerd_bus_sampler.sv
module eerd_bus_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl_o,
   output logic sda_lvl_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("eerd_bus_sampler: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [MSB:0] scl_sr, sda_sr;
   logic         scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sr <= '1;
         sda_sr <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sr <= {scl_sr[MSB-1:0], scl_i};
         sda_sr <= {sda_sr[MSB-1:0], sda_i};
         scl_d  <= scl_sr[MSB];
         sda_d  <= sda_sr[MSB];
      end
   end

   assign scl_lvl_o  = scl_sr[MSB];
   assign sda_lvl_o  = sda_sr[MSB];
   assign scl_rise_o = scl_sr[MSB] & ~scl_d;
   assign scl_fall_o = ~scl_sr[MSB] & scl_d;
   assign start_o    = scl_sr[MSB] & scl_d & ~sda_sr[MSB] & sda_d;
   assign stop_o     = scl_sr[MSB] & scl_d & sda_sr[MSB] & ~sda_d;
endmodule

// File: rtl/eerd_byte_array.sv
module eerd_byte_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              ld_en_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [7:0]        ld_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [7:0]        rd_data_o
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (ld_en_i) mem_q[ld_addr_i] <= ld_data_i;
   end

   assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eerd_read_fsm.sv
module eerd_read_fsm
   import eeprom_rd_pkg::*;
#(
   parameter int         ADDR_W  = 11,
   parameter logic [2:0] CHIP_EN = 3'b000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl_i,
   input  logic              sda_lvl_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic [7:0]        rd_data_i,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              sda_oe_o
);
   localparam logic [3:0] LAST_BIT = 4'(BITS_PER_SLOT - 1);

   phase_e            phase_q;
   logic [3:0]        cnt_q;
   logic              slot9_q;
   logic [7:0]        sh_q;
   logic [7:0]        tx_q;
   logic              rw_q;
   logic              oe_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_load;
   logic [2:0]        bit_idx;
   logic              sel_hit;
   logic              rx_phase;
   logic              ninth_rise;
   logic              hi_take;

   assign sel_hit    = (sh_q[7:4] == DEV_TYPE_CODE) && (sh_q[3:1] == CHIP_EN);
   assign rx_phase   = (phase_q == PH_SEL) || (phase_q == PH_AHI) || (phase_q == PH_ALO);
   assign ninth_rise = scl_rise_i && !start_i && !stop_i && (cnt_q == LAST_BIT);
   assign hi_take    = ninth_rise && (phase_q == PH_AHI);
   assign bit_idx    = 3'd7 - cnt_q[2:0];
   assign rd_addr_o  = (phase_q == PH_TX) ? addr_q + 1'b1 : addr_q;
   assign sda_oe_o   = oe_q;

   // Address assembly: keep only the high-byte bits the array uses.
   generate
      if (ADDR_W > 8) begin : g_hi
         logic [ADDR_W-9:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hi_q <= '0;
            else if (hi_take) hi_q <= sh_q[ADDR_W-9:0];
         end
         assign addr_load = {hi_q, sh_q};
      end else begin : g_nohi
         assign addr_load = sh_q[ADDR_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         slot9_q <= 1'b0;
         sh_q    <= '0;
         tx_q    <= '0;
         rw_q    <= 1'b0;
         oe_q    <= 1'b0;
         addr_q  <= '0;
      end else if (stop_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         slot9_q <= 1'b0;
         oe_q    <= 1'b0;
      end else if (start_i) begin
         phase_q <= PH_SEL;
         cnt_q   <= '0;
         slot9_q <= 1'b0;
         oe_q    <= 1'b0;
      end else if (scl_rise_i) begin
         if (cnt_q != LAST_BIT) begin
            cnt_q <= cnt_q + 4'd1;
            if (rx_phase) sh_q <= {sh_q[6:0], sda_lvl_i};
         end else begin
            cnt_q   <= '0;
            slot9_q <= 1'b1;
            case (phase_q)
               PH_SEL: begin
                  if (rw_q) begin
                     phase_q <= PH_TX;
                     tx_q    <= rd_data_i;
                  end else begin
                     phase_q <= PH_AHI;
                  end
               end
               PH_AHI: phase_q <= PH_ALO;
               PH_ALO: begin
                  addr_q  <= addr_load;
                  phase_q <= PH_WAIT;
               end
               PH_TX: begin
                  addr_q <= addr_q + 1'b1;
                  if (!sda_lvl_i) tx_q    <= rd_data_i;
                  else            phase_q <= PH_IDLE;
               end
               default: ;
            endcase
         end
      end else if (scl_fall_i) begin
         if (cnt_q == LAST_BIT) begin
            case (phase_q)
               PH_SEL: begin
                  if (sel_hit) begin
                     oe_q <= 1'b1;
                     rw_q <= sh_q[0];
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
               PH_AHI, PH_ALO: oe_q <= 1'b1;
               default:        oe_q <= 1'b0;
            endcase
         end else if (slot9_q) begin
            slot9_q <= 1'b0;
            oe_q    <= (phase_q == PH_TX) ? ~tx_q[7] : 1'b0;
         end else if (phase_q == PH_TX) begin
            oe_q <= ~tx_q[bit_idx];
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_BIT); // R11
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !oe_q); // R10
   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_lvl_i); // R12
   AST_START_TO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !stop_i) |=> (phase_q == PH_SEL && cnt_q == 4'd0)); // R11
   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (phase_q == PH_IDLE && !oe_q)); // R11
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ninth_rise && phase_q == PH_TX) |=> (addr_q == $past(addr_q) + 1'b1)); // R9
   AST_RX_ACK_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && phase_q != PH_TX && phase_q != PH_SEL) |-> (cnt_q == LAST_BIT || slot9_q)); // R3
endmodule

// File: rtl/eeprom_rd_target.sv
module eeprom_rd_target #(
   parameter int         ADDR_W      = 11,
   parameter logic [2:0] CHIP_EN     = 3'b000,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              ld_en_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [7:0]        ld_data_i
);
   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
         $error("eeprom_rd_target: ADDR_W must lie in 8..16");
      end
   endgenerate

   logic              scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
   logic [ADDR_W-1:0] rd_addr;
   logic [7:0]        rd_data;

   eerd_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(bus_start), .stop_o(bus_stop));

   eerd_byte_array #(.ADDR_W(ADDR_W)) u_array (
      .clk(clk), .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data));

   eerd_read_fsm #(.ADDR_W(ADDR_W), .CHIP_EN(CHIP_EN)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_lvl_i(scl_lvl), .sda_lvl_i(sda_lvl),
      .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
      .start_i(bus_start), .stop_i(bus_stop),
      .rd_data_i(rd_data), .rd_addr_o(rd_addr), .sda_oe_o(sda_oe_o));
endmodule

// File: tb/eeprom_rd_target_tb.sv
module eeprom_rd_target_tb_top;
   localparam int         AW = 10;
   localparam logic [2:0] CE = 3'b101;
   localparam int         Q  = 10;
   localparam logic [7:0] SEL_W = {4'b1010, CE, 1'b0};
   localparam logic [7:0] SEL_R = {4'b1010, CE, 1'b1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          m_scl = 1'b1, m_sda = 1'b1;
   logic          sda_oe;
   logic          bus_sda;
   logic          ld_en = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [7:0]    ld_data = '0;
   int            n_run = 0, n_fail = 0, viol = 0;
   logic          oe_d = 1'b0;
   bit            done = 1'b0;

   always #4 clk = ~clk;
   assign bus_sda = m_sda & ~sda_oe;

   eeprom_rd_target #(.ADDR_W(AW), .CHIP_EN(CE), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda), .sda_oe_o(sda_oe),
      .ld_en_i(ld_en), .ld_addr_i(ld_addr), .ld_data_i(ld_data));

   always @(negedge clk) begin
      if (rst_n && sda_oe && !oe_d && m_scl) viol++;
      oe_d <= sda_oe;
   end

   function automatic logic [7:0] pat(input int a);
      return 8'(a * 37 + 11 + (a >> 8));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic m_start();
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic m_stop();
      m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
   endtask

   task automatic send_bit(input logic b);
      m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = bus_sda; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic wr_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic rd_byte(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
      send_bit(~mack);
   endtask

   task automatic addr_phase(input logic [15:0] a, input string tag);
      logic ack;
      m_start();
      wr_byte(SEL_W, ack); chk(ack, {tag, " sel-w ack"}, ack, 1);
      wr_byte(a[15:8], ack); chk(ack, {tag, " addr-hi ack"}, ack, 1);
      wr_byte(a[7:0], ack);  chk(ack, {tag, " addr-lo ack"}, ack, 1);
   endtask

   task automatic cur_read(input int exp_a, input string tag);
      logic ack; logic [7:0] d;
      m_start();
      wr_byte(SEL_R, ack); chk(ack, {tag, " sel-r ack"}, ack, 1);
      rd_byte(1'b0, d);    chk(d == pat(exp_a), tag, d, pat(exp_a));
      m_stop();
   endtask

   task automatic t_reset();
      chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
      chk(bus_sda == 1'b1, "R1 bus idle", bus_sda, 1);
   endtask

   task automatic t_bad_select();
      logic ack; logic [7:0] d;
      m_start();
      wr_byte({4'b0101, CE, 1'b1}, ack); chk(!ack, "R2 wrong type nack", ack, 0);
      rd_byte(1'b0, d); chk(d == 8'hFF, "R2 no drive after wrong type", d, 8'hFF);
      m_stop();
      m_start();
      wr_byte({4'b1010, 3'b001, 1'b1}, ack); chk(!ack, "R2 wrong chip-enable nack", ack, 0);
      m_stop();
   endtask

   task automatic t_random_read();
      logic ack; logic [7:0] d;
      addr_phase(16'hF2A5, "R3");
      m_start();
      wr_byte(SEL_R, ack); chk(ack, "R5 sel-r ack", ack, 1);
      rd_byte(1'b0, d); chk(d == pat(10'h2A5), "R3 R5 random byte, upper bits ignored", d, pat(10'h2A5));
      m_stop();
      cur_read(10'h2A6, "R4 R8 current read after random");
   endtask

   task automatic t_seq_wrap();
      logic ack; logic [7:0] d;
      addr_phase(16'h03FE, "R7");
      m_start();
      wr_byte(SEL_R, ack); chk(ack, "R7 sel-r ack", ack, 1);
      rd_byte(1'b1, d); chk(d == pat(10'h3FE), "R7 seq byte 0", d, pat(10'h3FE));
      rd_byte(1'b1, d); chk(d == pat(10'h3FF), "R7 seq byte 1", d, pat(10'h3FF));
      rd_byte(1'b1, d); chk(d == pat(0), "R9 wrap to zero", d, pat(0));
      rd_byte(1'b0, d); chk(d == pat(1), "R9 after wrap", d, pat(1));
      m_stop();
      cur_read(2, "R8 counter after sequential");
   endtask

   task automatic t_rs_mismatch();
      logic ack; logic [7:0] d;
      addr_phase(16'h0055, "R6");
      m_start();
      wr_byte({4'b1010, 3'b011, 1'b1}, ack); chk(!ack, "R6 mismatched reselect nack", ack, 0);
      rd_byte(1'b0, d); chk(d == 8'hFF, "R6 standby no drive", d, 8'hFF);
      m_stop();
      cur_read(10'h055, "R6 counter kept");
   endtask

   task automatic t_nack_standby();
      logic ack; logic [7:0] d;
      m_start();
      wr_byte(SEL_R, ack); chk(ack, "R10 sel-r ack", ack, 1);
      rd_byte(1'b0, d); chk(d == pat(10'h056), "R10 byte before nack", d, pat(10'h056));
      wr_byte(8'hFF, ack);
      chk(!ack, "R10 no drive in slot after nack", ack, 0);
      m_stop();
      cur_read(10'h057, "R10 R8 single step after nack");
   endtask

   task automatic t_stop_mid();
      for (int i = 7; i >= 4; i--) send_bit(SEL_R[i]);
      m_stop();
      cur_read(10'h058, "R11 stop mid-byte");
   endtask

   task automatic t_start_mid();
      logic ack; logic [7:0] d;
      m_start();
      for (int i = 7; i >= 5; i--) send_bit(SEL_R[i]);
      m_start();
      wr_byte(SEL_R, ack); chk(ack, "R11 start mid-byte ack", ack, 1);
      rd_byte(1'b0, d); chk(d == pat(10'h059), "R11 start mid-byte data", d, pat(10'h059));
      m_stop();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      for (int a = 0; a < (1 << AW); a++) begin
         ld_en = 1'b1; ld_addr = AW'(a); ld_data = pat(a);
         @(negedge clk);
      end
      ld_en = 1'b0;
      wq();
      t_bad_select();
      t_random_read();
      t_seq_wrap();
      t_rs_mismatch();
      t_nack_standby();
      t_stop_mid();
      t_start_mid();
      chk(viol == 0, "R12 enable rose while clock high", viol, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual 0x0 expected 0x1");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule